// File: doc/BRIEF.md
# RS-232 Auto Power-Down Controller

This block is the digital power manager for a serial line transceiver. For every receiver it takes a two-bit level class from an analog comparator block outside this one. It combines these classes with three asynchronous control pins:
- a force-on pin;
- an active-low force-off pin;
- an active-low receiver enable.

From these it drives four outputs:
- the charge-pump enable;
- the transmitter output enable (transmitters are high impedance when it is low);
- the receiver output enable;
- a signal-present flag.

The flag falls only after every receiver has been classed invalid for a long window. It rises after a short run of valid levels on any receiver. In automatic mode the flag decides the power state. A wake-up sequence first enables the charge pump and releases the transmitters after a wake delay. It then allows a grace window in which valid levels must appear, or the block powers down again. The force-off pin overrides everything. The force-on pin keeps the transmitters up whatever the line does. All windows are parameters in clock cycles, with defaults derived from `CLK_HZ`: 30 µs invalid, 1 µs valid, 100 µs wake, 30 µs grace.

Top module: `rs232_pwr_ctl`

## Requirements
- R1: While the synchronized force-off pin is low, `pump_en` and `tx_oe` are low in the following cycle, whatever `force_on` and the line levels are.
- R2: With force-off high and force-on high, the block wakes from power-down and keeps `tx_oe` high without a grace-window fallback, whatever the line levels are.
- R3: Receiver i uses `lvl_code[2i+1:2i]`, where 2'b10 means invalid. `sig_present` falls in the cycle after the INV_CYC-th sample in which all receivers are invalid. A sample with any valid code clears that count.
- R4: A sample with no valid code and at least one indeterminate code (2'b00 or 2'b11) holds the invalid count: it neither resets nor advances it.
- R5: The code 2'b01 means valid. `sig_present` rises after VAL_CYC consecutive samples in which some receiver is valid. A shorter burst leaves it low.
- R6: `sig_present` is computed the same way in forced-on, forced-off and automatic modes.
- R7: In automatic mode (force-on low, force-off high), a low `sig_present` turns the block off in the next cycle. A high `sig_present` while off raises `pump_en` in the next cycle, and `tx_oe` follows WAKE_CYC cycles later.
- R8: After a wake in automatic mode, the block returns to power-down (pump and transmitters off) after GRACE_CYC cycles if `sig_present` has not risen. If it has risen, the block stays up.
- R9: `rx_oe` is the inverse of `rx_en_n`, delayed by a two-flop synchronizer, and does not depend on the power state.
- R10: Reset leaves all four outputs low. The first rise of the synchronized force-off level after reset starts a wake sequence, as a release of force-off does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_code | input | 2*NRX | Per-receiver level class: 01 valid, 10 invalid, others indeterminate |
| force_on | input | 1 | Asynchronous; high disables automatic power-down |
| force_off_n | input | 1 | Asynchronous; low forces power-down |
| rx_en_n | input | 1 | Asynchronous active-low receiver output enable |
| pump_en | output | 1 | Charge-pump enable |
| tx_oe | output | 1 | Transmitter output enable |
| rx_oe | output | 1 | Receiver output enable |
| sig_present | output | 1 | High when a valid line level is present |

## Verification
Timing is measured from the negative edge at which an input changes:
- A level-code change reaches `sig_present` after VAL_CYC or INV_CYC sampling edges.
- A power decision that follows the flag appears one cycle after the flag.
- A control-pin change reaches `rx_oe` after 2 cycles and `pump_en` after 3.
- `tx_oe` rises WAKE_CYC cycles after `pump_en`.

The driver queues each expected value with its due cycle, and the monitor compares it at exactly that negative edge. Most timing points are checked on both sides of the edge: the old value one cycle early and the new value on time. A queued item that is never matched counts as a failure.

// File: rtl/rs232_pwr_ctl.sv
module rs232_pwr_ctl #(
  parameter int CLK_HZ    = 200_000_000,
  parameter int NRX       = 1,
  parameter int INV_CYC   = (CLK_HZ / 1_000_000) * 30,
  parameter int VAL_CYC   = CLK_HZ / 1_000_000,
  parameter int WAKE_CYC  = (CLK_HZ / 1_000_000) * 100,
  parameter int GRACE_CYC = (CLK_HZ / 1_000_000) * 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*NRX-1:0] lvl_code,
  input  logic           force_on,
  input  logic           force_off_n,
  input  logic           rx_en_n,
  output logic           pump_en,
  output logic           tx_oe,
  output logic           rx_oe,
  output logic           sig_present
);

  localparam int IW   = $clog2(INV_CYC + 1);
  localparam int VW   = $clog2(VAL_CYC + 1);
  localparam int TMAX = (WAKE_CYC > GRACE_CYC) ? WAKE_CYC : GRACE_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_OFF, S_WAKE, S_GRACE, S_ON} pstate_t;

  logic [1:0] fo_sh, fon_sh, rxe_sh;
  logic       fo_s, fon_s, fo_d, fo_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fo_sh  <= 2'b00;
      fon_sh <= 2'b00;
      rxe_sh <= 2'b11;
      fo_d   <= 1'b0;
    end else begin
      fo_sh  <= {fo_sh[0], force_off_n};
      fon_sh <= {fon_sh[0], force_on};
      rxe_sh <= {rxe_sh[0], rx_en_n};
      fo_d   <= fo_s;
    end
  end

  assign fo_s    = fo_sh[1];
  assign fon_s   = fon_sh[1];
  assign fo_rise = fo_s & ~fo_d;
  assign rx_oe   = ~rxe_sh[1];

  logic [NRX-1:0] is_val, is_inv;
  logic           any_val, all_inv;

  for (genvar g = 0; g < NRX; g++) begin : g_rx
    assign is_val[g] = (lvl_code[2*g +: 2] == 2'b01);
    assign is_inv[g] = (lvl_code[2*g +: 2] == 2'b10);
  end

  assign any_val = |is_val;
  assign all_inv = &is_inv;

  logic [IW-1:0] icnt;
  logic [VW-1:0] vcnt;
  logic          sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt  <= IW'(INV_CYC);
      vcnt  <= '0;
      sig_q <= 1'b0;
    end else if (any_val) begin
      icnt <= '0;
      if (vcnt != VW'(VAL_CYC)) vcnt <= vcnt + 1'b1;
      if (vcnt >= VW'(VAL_CYC - 1)) sig_q <= 1'b1;
    end else begin
      vcnt <= '0;
      if (all_inv) begin
        if (icnt != IW'(INV_CYC)) icnt <= icnt + 1'b1;
        if (icnt >= IW'(INV_CYC - 1)) sig_q <= 1'b0;
      end
    end
  end

  assign sig_present = sig_q;

  pstate_t       st;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      tcnt <= '0;
    end else if (!fo_s) begin
      st   <= S_OFF;
      tcnt <= '0;
    end else begin
      case (st)
        S_OFF: begin
          if (fon_s || sig_q || fo_rise) begin
            st   <= S_WAKE;
            tcnt <= '0;
          end
        end
        S_WAKE: begin
          if (tcnt == TW'(WAKE_CYC - 1)) begin
            st   <= fon_s ? S_ON : S_GRACE;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_GRACE: begin
          if (fon_s || sig_q) begin
            st <= S_ON;
          end else if (tcnt == TW'(GRACE_CYC - 1)) begin
            st   <= S_OFF;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          if (!fon_s && !sig_q) st <= S_OFF;
        end
      endcase
    end
  end

  assign pump_en = (st != S_OFF);
  assign tx_oe   = (st == S_GRACE) || (st == S_ON);

endmodule

// File: rtl/rs232_pwr_ctl_chk.sv
module rs232_pwr_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic fo_s,
  input logic fo_d,
  input logic fon_s,
  input logic any_val,
  input logic all_inv,
  input logic pump_en,
  input logic tx_oe,
  input logic sig_present
);

  a_r1_force_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !fo_s |=> (!pump_en && !tx_oe));

  a_r2_forced_on_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_s && fon_s && tx_oe) |=> tx_oe);

  a_r3_fall_needs_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_present) |-> $past(all_inv));

  a_r5_rise_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_present) |-> $past(any_val));

  a_r7_tx_needs_pump: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> pump_en);

  a_r7_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_s && fo_d && !fon_s && !pump_en && !sig_present) |=> !pump_en);

endmodule

bind rs232_pwr_ctl rs232_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fo_s(fo_s), .fo_d(fo_d), .fon_s(fon_s),
  .any_val(any_val), .all_inv(all_inv), .pump_en(pump_en), .tx_oe(tx_oe),
  .sig_present(sig_present)
);

// File: tb/rs232_pwr_ctl_tb.sv
`timescale 1ns/1ps
module rs232_pwr_ctl_tb;
  localparam int NRX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*NRX-1:0] lvl_code = 4'b1010;
  logic force_on = 1'b0, force_off_n = 1'b1, rx_en_n = 1'b0;
  logic pump_en, tx_oe, rx_oe, sig_present;

  always #2.5 clk = ~clk;

  rs232_pwr_ctl #(.CLK_HZ(200_000_000), .NRX(NRX), .INV_CYC(8), .VAL_CYC(3),
                  .WAKE_CYC(10), .GRACE_CYC(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .lvl_code(lvl_code), .force_on(force_on),
    .force_off_n(force_off_n), .rx_en_n(rx_en_n), .pump_en(pump_en),
    .tx_oe(tx_oe), .rx_oe(rx_oe), .sig_present(sig_present));

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    q_due[$];
  int    q_sel[$];
  bit    q_val[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic get_out(input int sel);
    case (sel)
      0: return pump_en;
      1: return tx_oe;
      2: return rx_oe;
      default: return sig_present;
    endcase
  endfunction

  function automatic string out_name(input int sel);
    case (sel)
      0: return "pump_en";
      1: return "tx_oe";
      2: return "rx_oe";
      default: return "sig_present";
    endcase
  endfunction

  task automatic expect_at(input int dly, input int sel, input bit v, input string tag);
    q_due.push_back(cyc + dly);
    q_sel.push_back(sel);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    for (int i = q_due.size() - 1; i >= 0; i--) begin
      if (q_due[i] <= cyc) begin
        logic a;
        a = get_out(q_sel[i]);
        checks++;
        if (q_due[i] < cyc || a !== q_val[i]) begin
          errors++;
          $display("FAIL %s %s at cycle %0d: actual %b expected %b", q_tag[i],
                   out_name(q_sel[i]), q_due[i], a, q_val[i]);
        end
        q_due.delete(i); q_sel.delete(i); q_val.delete(i); q_tag.delete(i);
      end
    end
  end

  initial begin
    idle(3);
    expect_at(1, 0, 1'b0, "R10"); expect_at(1, 1, 1'b0, "R10");
    expect_at(1, 2, 1'b0, "R10"); expect_at(1, 3, 1'b0, "R10");
    idle(2);
    rst_n = 1'b1;
    expect_at(1, 2, 1'b0, "R9");  expect_at(2, 2, 1'b1, "R9");
    expect_at(2, 0, 1'b0, "R10"); expect_at(3, 0, 1'b1, "R10");
    expect_at(12, 1, 1'b0, "R8"); expect_at(13, 1, 1'b1, "R8");
    expect_at(18, 1, 1'b1, "R8"); expect_at(19, 1, 1'b0, "R8");
    expect_at(18, 0, 1'b1, "R8"); expect_at(19, 0, 1'b0, "R8");
    idle(25);

    lvl_code = 4'b1001;
    expect_at(2, 3, 1'b0, "R5"); expect_at(3, 3, 1'b1, "R5");
    expect_at(3, 0, 1'b0, "R7"); expect_at(4, 0, 1'b1, "R7");
    expect_at(13, 1, 1'b0, "R7"); expect_at(14, 1, 1'b1, "R7");
    expect_at(20, 1, 1'b1, "R8");
    idle(22);

    lvl_code = 4'b1010;
    expect_at(12, 3, 1'b1, "R4"); expect_at(13, 3, 1'b0, "R3");
    expect_at(13, 0, 1'b1, "R7"); expect_at(14, 0, 1'b0, "R7");
    expect_at(14, 1, 1'b0, "R7");
    idle(7);
    lvl_code = 4'b1000;
    idle(5);
    lvl_code = 4'b1010;
    idle(10);

    lvl_code = 4'b1001;
    expect_at(3, 3, 1'b0, "R5"); expect_at(5, 3, 1'b0, "R5");
    expect_at(6, 0, 1'b0, "R7");
    idle(2);
    lvl_code = 4'b1010;
    idle(12);

    force_on = 1'b1;
    expect_at(2, 0, 1'b0, "R2"); expect_at(3, 0, 1'b1, "R2");
    expect_at(13, 1, 1'b1, "R2"); expect_at(30, 1, 1'b1, "R2");
    expect_at(30, 3, 1'b0, "R6");
    idle(32);

    force_off_n = 1'b0;
    lvl_code = 4'b0110;
    expect_at(2, 0, 1'b1, "R1"); expect_at(3, 0, 1'b0, "R1");
    expect_at(3, 1, 1'b0, "R1"); expect_at(3, 3, 1'b1, "R6");
    expect_at(10, 0, 1'b0, "R1");
    idle(12);
    force_on = 1'b0;
    rx_en_n = 1'b1;
    expect_at(1, 2, 1'b1, "R9"); expect_at(2, 2, 1'b0, "R9");
    idle(4);
    rx_en_n = 1'b0;
    expect_at(2, 2, 1'b1, "R9"); expect_at(2, 0, 1'b0, "R9");
    idle(4);

    force_off_n = 1'b1;
    expect_at(2, 0, 1'b0, "R10"); expect_at(3, 0, 1'b1, "R10");
    expect_at(13, 1, 1'b1, "R7");
    expect_at(25, 1, 1'b1, "R8"); expect_at(25, 0, 1'b1, "R8");
    idle(30);

    while (q_due.size() != 0) idle(1);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule